// File: doc/BRIEF.md
# Shared-Window Write Mirroring Bridge

This block connects one node's local system bus to a replication bus shared by several nodes. The aim is that a chosen range of memory holds the same contents on every node. On the local side it observes every bus cycle. A write whose 24-bit address lies inside a programmable window is copied into an outbound queue, and that queue drains onto the replication bus. Reads, writes outside the window, and writes that the bridge itself replayed are left alone.

On the remote side the bridge accepts words from the replication bus. Words whose address lies in the same window go into an inbound queue. That queue replays them, in arrival order, through a memory write port into local memory.

Neither direction ever stalls the local bus. If the outbound queue is full, the write is dropped and a sticky overflow bit records the loss. The inbound side instead deasserts its ready. A small register interface sets the window's lower and upper bounds and gives access to the overflow bit.

Top module: `refl_bridge`

## Requirements
- R1: A local cycle with `lb_valid`=1, `lb_write`=1 and `lb_replay`=0 is queued for the replication bus exactly when base <= `lb_addr` <= limit, with both bounds inclusive. Reads and addresses outside that range are never sent.
- R2: After reset, base is 0xFFFFFF and limit is 0x000000, so the window is empty. The overflow bit is 0, `tx_valid` and `mem_we` are 0, and `rx_ready` is 1.
- R3: Outbound words leave on `tx_addr`/`tx_data` in the order they were written on the local bus. A word transfers on a cycle where `tx_valid` and `tx_ready` are both 1. While `tx_ready` is 0, the presented word is held unchanged.
- R4: The outbound queue holds 16 words. A qualifying write that arrives while 16 words are queued is discarded and sets overflow status bit 0.
- R5: Writing status with bit 0 = 1 clears the overflow bit. Writing bit 0 = 0 leaves it unchanged. If a drop and a clear happen in the same cycle, the bit is set.
- R6: A local write with `lb_replay`=1 is never queued for the replication bus, even when it falls inside the window.
- R7: A replication-bus word accepted while `rx_valid` and `rx_ready` are both 1 is replayed on the memory port when its address is inside the window, in arrival order. Otherwise it is consumed and discarded.
- R8: `rx_ready` is 0 exactly while 16 words wait in the inbound queue, so no remote word is lost. A memory write stays presented, unchanged, until `mem_ready` is 1.
- R9: Configuration register index 0 is the base and index 1 is the limit, each in bits 23:0. Index 2 is status, with overflow in bit 0. `cfg_rdata` shows the register that `cfg_addr` selected at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_valid | input | 1 | Local bus cycle present |
| lb_write | input | 1 | Local cycle is a write |
| lb_replay | input | 1 | Local cycle was issued by this bridge's replay |
| lb_addr | input | 24 | Local bus address |
| lb_data | input | 32 | Local bus write data |
| tx_valid | output | 1 | Outbound word available |
| tx_ready | input | 1 | Replication bus accepts outbound word |
| tx_addr | output | 24 | Outbound address |
| tx_data | output | 32 | Outbound data |
| rx_valid | input | 1 | Remote word present |
| rx_ready | output | 1 | Bridge can take a remote word |
| rx_addr | input | 24 | Remote address |
| rx_data | input | 32 | Remote data |
| mem_we | output | 1 | Replay write request to local memory |
| mem_ready | input | 1 | Local memory takes the replay write |
| mem_addr | output | 24 | Replay address |
| mem_data | output | 32 | Replay data |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |

## Verification
The hold properties assume that nothing withdraws a word mid-handshake on the consumer side. They say only that the bridge keeps its own outbound and replay words stable until `tx_ready` or `mem_ready` takes them. The stimulus may therefore toggle those ready inputs freely.

The overflow properties assume the window registers are changed only while the local bus is idle. The random phase programs the window once and then leaves it alone, and the directed phases reprogram it only between bursts. Remote senders are allowed to drop `rx_valid` at any time; the bench models acceptance purely from the sampled `rx_ready`.

// File: rtl/refl_pkg.sv
package refl_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int WORD_W = ADDR_W + DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } mirror_word_t;

  localparam logic [1:0] IDX_BASE  = 2'd0;
  localparam logic [1:0] IDX_LIMIT = 2'd1;
  localparam logic [1:0] IDX_STAT  = 2'd2;
endpackage

// File: rtl/refl_win_match.sv
module refl_win_match #(
  parameter int AW = 24
) (
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  always_comb hit = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/refl_fifo.sv
module refl_fifo #(
  parameter int W     = 56,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic         dvalid,
  output logic [W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  ram [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] fill, held;
  logic          do_push, take, load;

  always_comb begin
    full    = (fill == CW'(DEPTH));
    do_push = push && !full;
    take    = dvalid && pop;
    load    = (held != '0) && (!dvalid || take);
  end

  always_ff @(posedge clk) begin
    if (do_push) ram[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (load) dout <= ram[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      fill   <= '0;
      held   <= '0;
      dvalid <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      if (load)    rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      held <= held + CW'(do_push) - CW'(load);
      fill <= fill + CW'(do_push) - CW'(take);
      if (load)      dvalid <= 1'b1;
      else if (take) dvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/refl_regs.sv
module refl_regs
  import refl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              ovf_set,
  output logic [ADDR_W-1:0] win_lo,
  output logic [ADDR_W-1:0] win_hi,
  output logic              ovf,
  output logic [31:0]       cfg_rdata
);
  logic ovf_clr;
  always_comb ovf_clr = cfg_we && (cfg_addr == IDX_STAT) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_lo    <= '1;
      win_hi    <= '0;
      ovf       <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_we && cfg_addr == IDX_BASE)  win_lo <= cfg_wdata[ADDR_W-1:0];
      if (cfg_we && cfg_addr == IDX_LIMIT) win_hi <= cfg_wdata[ADDR_W-1:0];
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      case (cfg_addr)
        IDX_BASE:  cfg_rdata <= 32'(win_lo);
        IDX_LIMIT: cfg_rdata <= 32'(win_hi);
        IDX_STAT:  cfg_rdata <= {31'd0, ovf};
        default:   cfg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/refl_bridge.sv
module refl_bridge
  import refl_pkg::*;
#(
  parameter int QDEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lb_valid,
  input  logic              lb_write,
  input  logic              lb_replay,
  input  logic [ADDR_W-1:0] lb_addr,
  input  logic [DATA_W-1:0] lb_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [DATA_W-1:0] rx_data,
  output logic              mem_we,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);
  logic [ADDR_W-1:0] win_lo, win_hi;
  logic              ovf_flag, ob_hit, ib_hit, ob_cand, ob_full, ib_full, ib_push;
  mirror_word_t      ob_in, ob_out, ib_in, ib_out;

  refl_regs u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ovf_set(ob_cand && ob_full),
    .win_lo(win_lo), .win_hi(win_hi), .ovf(ovf_flag), .cfg_rdata(cfg_rdata)
  );

  refl_win_match #(.AW(ADDR_W)) u_ob_match (
    .lo(win_lo), .hi(win_hi), .addr(lb_addr), .hit(ob_hit)
  );
  refl_win_match #(.AW(ADDR_W)) u_ib_match (
    .lo(win_lo), .hi(win_hi), .addr(rx_addr), .hit(ib_hit)
  );

  always_comb begin
    ob_cand    = lb_valid && lb_write && !lb_replay && ob_hit;
    ob_in.addr = lb_addr;
    ob_in.data = lb_data;
    rx_ready   = !ib_full;
    ib_push    = rx_valid && rx_ready && ib_hit;
    ib_in.addr = rx_addr;
    ib_in.data = rx_data;
    tx_addr    = ob_out.addr;
    tx_data    = ob_out.data;
    mem_addr   = ib_out.addr;
    mem_data   = ib_out.data;
  end

  refl_fifo #(.W(WORD_W), .DEPTH(QDEPTH)) u_ob_q (
    .clk(clk), .rst(rst), .push(ob_cand), .din(ob_in), .full(ob_full),
    .pop(tx_ready), .dvalid(tx_valid), .dout(ob_out)
  );

  refl_fifo #(.W(WORD_W), .DEPTH(QDEPTH)) u_ib_q (
    .clk(clk), .rst(rst), .push(ib_push), .din(ib_in), .full(ib_full),
    .pop(mem_ready), .dvalid(mem_we), .dout(ib_out)
  );
endmodule

// File: rtl/refl_bridge_chk.sv
module refl_bridge_chk
  import refl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [ADDR_W-1:0] tx_addr,
  input logic [DATA_W-1:0] tx_data,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              ovf,
  input logic              ob_cand,
  input logic              ob_full
);
  logic clr;
  always_comb clr = cfg_we && (cfg_addr == IDX_STAT) && cfg_wdata[0];

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_addr) && $stable(tx_data)); // R3
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_we && !mem_ready |=> mem_we && $stable(mem_addr) && $stable(mem_data)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf && !clr |=> ovf); // R5
  AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    ob_cand && ob_full |=> ovf); // R4
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tx_valid && !mem_we && !ovf); // R2
endmodule

bind refl_bridge refl_bridge_chk u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_addr(tx_addr), .tx_data(tx_data), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .ovf(ovf_flag), .ob_cand(ob_cand), .ob_full(ob_full)
);

// File: tb/sim_refl_bridge.sv
module sim_refl_bridge;
  localparam int QD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lb_valid = 0, lb_write = 0, lb_replay = 0;
  logic [23:0] lb_addr = '0;
  logic [31:0] lb_data = '0;
  logic tx_valid, tx_ready = 0;
  logic [23:0] tx_addr;
  logic [31:0] tx_data;
  logic rx_valid = 0, rx_ready;
  logic [23:0] rx_addr = '0;
  logic [31:0] rx_data = '0;
  logic mem_we, mem_ready = 0;
  logic [23:0] mem_addr;
  logic [31:0] mem_data;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;

  int nchk = 0, nfail = 0;
  logic [55:0] txq[$];
  logic [55:0] ibq[$];
  logic [23:0] base_m = 24'hFFFFFF, lim_m = 24'h0;
  logic ovf_m = 1'b0;

  always #2 clk = ~clk;

  refl_bridge u0 (.*);

  function automatic logic in_win(logic [23:0] a);
    return (a >= base_m) && (a <= lim_m);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: model the coming edge from the driven inputs, then advance
  task automatic cyc();
    int tsz = txq.size();
    int isz = ibq.size();
    logic drop = 1'b0;
    logic [55:0] w;
    if (tx_valid && tx_ready) begin
      if (tsz == 0) chk("R3 unexpected outbound word", {tx_addr, tx_data}, 0);
      else begin w = txq.pop_front(); chk("R3 outbound order", {tx_addr, tx_data}, w); end
    end
    if (lb_valid && lb_write && !lb_replay && in_win(lb_addr)) begin
      if (tsz < QD) txq.push_back({lb_addr, lb_data});
      else drop = 1'b1;
    end
    chk("R8 rx_ready", rx_ready, isz < QD);
    if (mem_we && mem_ready) begin
      if (isz == 0) chk("R7 unexpected replay", {mem_addr, mem_data}, 0);
      else begin w = ibq.pop_front(); chk("R7 replay order", {mem_addr, mem_data}, w); end
    end
    if (rx_valid && rx_ready && in_win(rx_addr)) ibq.push_back({rx_addr, rx_data});
    if (drop) ovf_m = 1'b1;
    else if (cfg_we && cfg_addr == 2'd2 && cfg_wdata[0]) ovf_m = 1'b0;
    if (cfg_we && cfg_addr == 2'd0) base_m = cfg_wdata[23:0];
    if (cfg_we && cfg_addr == 2'd1) lim_m = cfg_wdata[23:0];
    @(negedge clk);
  endtask

  task automatic cfg_wr(logic [1:0] a, logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; cyc(); cfg_we = 0;
  endtask

  task automatic cfg_rd(string req, logic [1:0] a, logic [31:0] exp);
    cfg_addr = a; cyc(); chk(req, cfg_rdata, exp);
  endtask

  task automatic lb_wr(logic [23:0] a, logic [31:0] d, logic rep);
    lb_valid = 1; lb_write = 1; lb_replay = rep; lb_addr = a; lb_data = d;
    cyc(); lb_valid = 0; lb_replay = 0;
  endtask

  task automatic drain();
    lb_valid = 0; rx_valid = 0; tx_ready = 1; mem_ready = 1;
    repeat (40) cyc();
    chk("R1 outbound drained", txq.size(), 0);
    chk("R7 inbound drained", ibq.size(), 0);
    chk("R3 tx idle", tx_valid, 0);
  endtask

  function automatic logic [23:0] pick_addr();
    case ($urandom % 6)
      0: return base_m - 24'd1;
      1: return base_m;
      2: return lim_m;
      3: return lim_m + 24'd1;
      4: return 24'($urandom);
      default: return base_m + 24'($urandom % 32'h1000);
    endcase
  endfunction

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R2 tx_valid", tx_valid, 0);
    chk("R2 mem_we", mem_we, 0);
    chk("R2 rx_ready", rx_ready, 1);
    cfg_rd("R2 R9 base", 2'd0, 32'h00FFFFFF);
    cfg_rd("R2 R9 limit", 2'd1, 32'h0);
    cfg_rd("R2 status", 2'd2, 32'h0);
    // empty window forwards nothing
    tx_ready = 1;
    lb_wr(24'h000000, 32'h11, 0);
    lb_wr(24'hFFFFFF, 32'h22, 0);
    repeat (4) cyc();
    chk("R2 empty window", tx_valid, 0);
    // single-address window, inclusive bounds, reads and replays
    cfg_wr(2'd0, 32'h000100);
    cfg_wr(2'd1, 32'h000100);
    cfg_rd("R9 base readback", 2'd0, 32'h100);
    lb_wr(24'h0000FF, 32'hA0, 0);
    lb_wr(24'h000100, 32'hA1, 0);
    lb_wr(24'h000101, 32'hA2, 0);
    lb_wr(24'h000100, 32'hA3, 1); // R6
    lb_valid = 1; lb_write = 0; lb_addr = 24'h100; cyc(); lb_valid = 0;
    drain();
    // overflow: 20 writes while tx stalls
    cfg_wr(2'd0, 32'h001000);
    cfg_wr(2'd1, 32'h001FFF);
    tx_ready = 0;
    for (int i = 0; i < 20; i++) lb_wr(24'h001000 + 24'(i), 32'hB000 + i, 0);
    chk("R4 queue holds 16", txq.size(), 16);
    cfg_rd("R4 overflow set", 2'd2, 32'h1);
    cfg_wr(2'd2, 32'h0);
    cfg_rd("R5 write 0 keeps", 2'd2, 32'h1);
    cfg_wr(2'd2, 32'h1);
    cfg_rd("R5 write 1 clears", 2'd2, 32'h0);
    drain();
    // inbound backpressure with memory stalled
    mem_ready = 0;
    for (int i = 0; i < 20; i++) begin
      rx_valid = 1; rx_addr = 24'h001800 + 24'(i); rx_data = 32'hC000 + i;
      cyc();
    end
    rx_valid = 0;
    chk("R8 rx_ready low when full", rx_ready, 0);
    drain();
    // random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      lb_valid  = ($urandom % 10) < 4;
      lb_write  = ($urandom % 10) < 7;
      lb_replay = ($urandom % 10) == 0;
      lb_addr   = pick_addr();
      lb_data   = $urandom;
      rx_valid  = ($urandom % 10) < 5;
      rx_addr   = pick_addr();
      rx_data   = $urandom;
      tx_ready  = ($urandom % 10) < 5;
      mem_ready = ($urandom % 10) < 6;
      if (n % 700 == 699) begin cfg_we = 1; cfg_addr = 2'd2; cfg_wdata = 32'h1; end
      cyc();
      cfg_we = 0;
    end
    drain();
    cfg_rd("R4 R5 status after random", 2'd2, {31'd0, ovf_m});
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule